// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block sits between an instruction byte source and an execution stage. Bytes arrive one per accepted cycle on a simple valid/data input. The first byte of each instruction is the opcode. From it the block looks up how many bytes the instruction spans, which register fields its second byte carries and where its operand bytes lie. It gathers the rest of the bytes and then presents one decoded instruction. Idle cycles between bytes are allowed and do not disturb a partly collected instruction.

The decoded result gives the opcode, an operation class, up to two register codes, an operand kind, the assembled operand value and the total byte length. It is registered and marked by a one-cycle valid strobe. An opcode that is not in the table, or a used register field that holds no valid register, gives a one-cycle illegal strobe instead. After either strobe the next byte is taken as a fresh opcode.

Top module: `insn_decoder`

## Requirements
- R1: While reset is held, and in the cycles after it is released, `dec_valid` and `dec_illegal` are 0.
- R2: Lengths are as follows. 0x90 and 0xF0 take 1 byte. 0x02, 0x04–0x0B, 0x15, 0x16, 0x20, 0x22, 0x24, 0x31 and 0x48–0x4F take 2 bytes. 0x50 takes 3 bytes. 0x21, 0x23, 0x30 and 0x40–0x47 take 5 bytes. 0x01, 0x03 and 0x0C–0x14 take 6 bytes. `dec_valid` is high for exactly the cycle after the last byte is accepted, with `dec_len` equal to the length. Neither strobe rises after any earlier byte.
- R3: Byte 1 is the register byte for these forms. In the two-register forms (0x02, 0x04–0x0B), bits 7:4 go to `dec_reg_a` and bits 3:0 go to `dec_reg_b`. For 0x01, 0x03, 0x0C–0x16, 0x22 and 0x50, bits 7:4 give `dec_reg_a`. For 0x20, 0x24, 0x31 and 0x48–0x4F, bits 3:0 give `dec_reg_a`. An unused register field or nibble reads 0 and is never checked.
- R4: 32-bit operands are taken least significant byte first. For 6-byte forms they are bytes 2–5, and for 5-byte forms they are bytes 1–4. For 0x50, `dec_imm` is byte 2 zero-extended. For all other forms, `dec_imm` is 0.
- R5: `dec_class` is coded as follows. MOVE=0 for 0x01–0x05 and 0x14. ALU=1 for 0x06–0x13, 0x15 and 0x16. STACK=2 for 0x20–0x22. BRANCH=3 for 0x23, 0x24, 0x30, 0x31 and 0x40–0x4F. IO=5 for 0x50. NOP=6 for 0x90. HALT=7 for 0xF0.
- R6: `dec_kind` is coded as follows. NONE=0 for 1-byte forms. REG=1 for the register-only forms and for 0x02 and 0x06–0x0B. IMM=2 for 0x01, 0x0C–0x14 and 0x21. MEM=3 for 0x03, 0x23, 0x30 and 0x40–0x47. PORT=4 for 0x50. INDIRECT=5 for 0x04 and 0x05.
- R7: Opcode 0x22 with register code 4 (the instruction pointer) decodes with class RETURN=4.
- R8: An opcode outside R2's list pulses `dec_illegal` in the cycle after it is accepted, with no `dec_valid`. The next byte is then decoded as an opcode.
- R9: If a used register field holds a code of 7 or more (valid codes are 0–6), `dec_illegal` pulses instead of `dec_valid` in the cycle after the last byte.
- R10: Cycles with `in_valid` low add no byte. The decoded fields, including `dec_opcode`, change only together with a `dec_valid` pulse and hold through idle cycles and illegal strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | 8 | Instruction stream byte |
| dec_valid | output | 1 | One-cycle strobe: a decoded instruction is presented |
| dec_illegal | output | 1 | One-cycle strobe: bad opcode or register code |
| dec_opcode | output | 8 | Opcode of the decoded instruction |
| dec_class | output | 3 | Operation class (R5, R7) |
| dec_kind | output | 3 | Operand kind (R6) |
| dec_reg_a | output | 4 | First or only register code |
| dec_reg_b | output | 4 | Second register code of two-register forms |
| dec_imm | output | 32 | Assembled operand value |
| dec_len | output | 3 | Instruction length in bytes |

## Verification
Directed streams cover several cases. One-byte forms tell length-1 issue apart from multi-byte collection. A return is contrasted with an ordinary pop, and a byte-ordered operand distinguishes little-endian from reversed assembly. A bad opcode followed at once by a valid one shows that the stream recovers. A code-7 nibble in a used field and in an unused field separates a checked field from an ignored one. Constrained random instructions then mix every listed opcode, random idle gaps, back-to-back bytes, occasional unlisted opcodes and invalid register nibbles. This exercises collection across gaps against single-cycle streaming.

// File: rtl/vdec_pkg.sv
package vdec_pkg;
  localparam int BYTE_W    = 8;
  localparam int IMM_BYTES = 4;
  localparam int IMM_W     = BYTE_W * IMM_BYTES;
  localparam int LEN_W     = 3;
  localparam int REG_W     = 4;
  localparam logic [BYTE_W-1:0] OPC_POP = 8'h22;
  localparam logic [REG_W-1:0]  REG_IP  = 4'd4;

  typedef enum logic [2:0] {
    CL_MOVE, CL_ALU, CL_STACK, CL_BRANCH, CL_RETURN, CL_IO, CL_NOP, CL_HALT
  } op_class_e;

  typedef enum logic [2:0] {
    K_NONE, K_REG, K_IMM, K_MEM, K_PORT, K_IND
  } opnd_kind_e;

  typedef enum logic [1:0] {RS_NONE, RS_HI, RS_LO, RS_PAIR} reg_sel_e;

  typedef struct packed {
    logic             legal;
    logic [LEN_W-1:0] len;
    op_class_e        cls;
    opnd_kind_e       kind;
    reg_sel_e         rsel;
  } op_info_t;
endpackage

// File: rtl/vdec_optable.sv
module vdec_optable
  import vdec_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output op_info_t          info
);
  localparam int LEN_PAIR = IMM_BYTES + 2;
  localparam int LEN_ONE  = IMM_BYTES + 1;

  function automatic op_info_t mk(input int len, input op_class_e c,
                                  input opnd_kind_e k, input reg_sel_e s);
    op_info_t r;
    r.legal = 1'b1;
    r.len   = LEN_W'(len);
    r.cls   = c;
    r.kind  = k;
    r.rsel  = s;
    return r;
  endfunction

  always_comb begin
    info       = mk(1, CL_NOP, K_NONE, RS_NONE);
    info.legal = 1'b0;
    case (opc) inside
      8'h01:          info = mk(LEN_PAIR, CL_MOVE,   K_IMM,  RS_HI);
      8'h02:          info = mk(2,        CL_MOVE,   K_REG,  RS_PAIR);
      8'h03:          info = mk(LEN_PAIR, CL_MOVE,   K_MEM,  RS_HI);
      8'h04, 8'h05:   info = mk(2,        CL_MOVE,   K_IND,  RS_PAIR);
      [8'h06:8'h0B]:  info = mk(2,        CL_ALU,    K_REG,  RS_PAIR);
      [8'h0C:8'h13]:  info = mk(LEN_PAIR, CL_ALU,    K_IMM,  RS_HI);
      8'h14:          info = mk(LEN_PAIR, CL_MOVE,   K_IMM,  RS_HI);
      8'h15, 8'h16:   info = mk(2,        CL_ALU,    K_REG,  RS_HI);
      8'h20:          info = mk(2,        CL_STACK,  K_REG,  RS_LO);
      8'h21:          info = mk(LEN_ONE,  CL_STACK,  K_IMM,  RS_NONE);
      8'h22:          info = mk(2,        CL_STACK,  K_REG,  RS_HI);
      8'h23, 8'h30:   info = mk(LEN_ONE,  CL_BRANCH, K_MEM,  RS_NONE);
      8'h24, 8'h31:   info = mk(2,        CL_BRANCH, K_REG,  RS_LO);
      [8'h40:8'h47]:  info = mk(LEN_ONE,  CL_BRANCH, K_MEM,  RS_NONE);
      [8'h48:8'h4F]:  info = mk(2,        CL_BRANCH, K_REG,  RS_LO);
      8'h50:          info = mk(3,        CL_IO,     K_PORT, RS_HI);
      8'h90:          info = mk(1,        CL_NOP,    K_NONE, RS_NONE);
      8'hF0:          info = mk(1,        CL_HALT,   K_NONE, RS_NONE);
      default:        ;
    endcase
  end
endmodule

// File: rtl/vdec_collect.sv
module vdec_collect
  import vdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              fin,
  output op_info_t          fin_info,
  output logic [BYTE_W-1:0] fin_opc,
  output logic [BYTE_W-1:0] fin_regbyte,
  output logic [IMM_W-1:0]  fin_imm
);
  localparam int LEN_PAIR = IMM_BYTES + 2;
  localparam int LEN_ONE  = IMM_BYTES + 1;

  logic              busy_q, busy_n;
  logic [LEN_W-1:0]  cnt_q, cnt_n;
  logic [BYTE_W-1:0] opc_q, opc_n;
  logic [BYTE_W-1:0] rb_q, rb_n;
  logic [IMM_W-1:0]  imm_q, imm_n;

  logic [BYTE_W-1:0] cur_opc, rb_base, rb_cur;
  logic [IMM_W-1:0]  imm_base, imm_cur;
  logic [LEN_W-1:0]  idx;
  op_info_t          info;
  logic              is_last, is_reg, is_wide, is_port;

  assign cur_opc = busy_q ? opc_q : in_byte;

  vdec_optable u_tab (.opc(cur_opc), .info(info));

  always_comb begin
    idx      = busy_q ? cnt_q : '0;
    rb_base  = busy_q ? rb_q  : '0;
    imm_base = busy_q ? imm_q : '0;
    is_last  = (idx == info.len - LEN_W'(1));
    is_reg   = (idx == LEN_W'(1)) && (info.rsel != RS_NONE);
    is_wide  = ((info.len == LEN_W'(LEN_PAIR)) && (idx >= LEN_W'(2))) ||
               ((info.len == LEN_W'(LEN_ONE))  && (idx >= LEN_W'(1)));
    is_port  = (info.kind == K_PORT) && (idx == LEN_W'(2));
    rb_cur   = is_reg ? in_byte : rb_base;
    if (is_wide)      imm_cur = {in_byte, imm_base[IMM_W-1:BYTE_W]};
    else if (is_port) imm_cur = {{(IMM_W-BYTE_W){1'b0}}, in_byte};
    else              imm_cur = imm_base;
  end

  always_comb begin
    busy_n = busy_q;
    cnt_n  = cnt_q;
    opc_n  = opc_q;
    rb_n   = rb_q;
    imm_n  = imm_q;
    if (in_valid) begin
      busy_n = !is_last;
      cnt_n  = is_last ? '0 : idx + LEN_W'(1);
      opc_n  = cur_opc;
      rb_n   = rb_cur;
      imm_n  = imm_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      opc_q  <= '0;
      rb_q   <= '0;
      imm_q  <= '0;
    end else if (in_valid) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      opc_q  <= opc_n;
      rb_q   <= rb_n;
      imm_q  <= imm_n;
    end
  end

  assign fin         = in_valid && is_last;
  assign fin_info    = info;
  assign fin_opc     = cur_opc;
  assign fin_regbyte = rb_cur;
  assign fin_imm     = imm_cur;
endmodule

// File: rtl/vdec_finish.sv
module vdec_finish
  import vdec_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin,
  input  op_info_t          fin_info,
  input  logic [BYTE_W-1:0] fin_opc,
  input  logic [BYTE_W-1:0] fin_regbyte,
  input  logic [IMM_W-1:0]  fin_imm,
  output logic              o_valid,
  output logic              o_illegal,
  output logic [BYTE_W-1:0] o_opcode,
  output logic [2:0]        o_class,
  output logic [2:0]        o_kind,
  output logic [REG_W-1:0]  o_reg_a,
  output logic [REG_W-1:0]  o_reg_b,
  output logic [IMM_W-1:0]  o_imm,
  output logic [LEN_W-1:0]  o_len
);
  localparam int SLOTS = 2;

  logic [REG_W-1:0] hi_nib, lo_nib, reg_a, reg_b;
  logic [REG_W-1:0] slot_code [SLOTS];
  logic [SLOTS-1:0] slot_used, slot_bad;
  op_class_e        cls;
  logic             good_n, bad_n;

  assign hi_nib = fin_regbyte[BYTE_W-1:BYTE_W-REG_W];
  assign lo_nib = fin_regbyte[REG_W-1:0];

  always_comb begin
    reg_a = '0;
    reg_b = '0;
    case (fin_info.rsel)
      RS_HI:   reg_a = hi_nib;
      RS_LO:   reg_a = lo_nib;
      RS_PAIR: begin reg_a = hi_nib; reg_b = lo_nib; end
      default: ;
    endcase
  end

  assign slot_code[0] = reg_a;
  assign slot_code[1] = reg_b;
  assign slot_used[0] = (fin_info.rsel != RS_NONE);
  assign slot_used[1] = (fin_info.rsel == RS_PAIR);

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_bad[g] = slot_used[g] && (slot_code[g] >= REG_W'(NUM_REGS));
  end

  assign cls    = ((fin_opc == OPC_POP) && (reg_a == REG_IP)) ? CL_RETURN : fin_info.cls;
  assign good_n = fin && fin_info.legal && (slot_bad == '0);
  assign bad_n  = fin && !(fin_info.legal && (slot_bad == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid   <= 1'b0;
      o_illegal <= 1'b0;
    end else begin
      o_valid   <= good_n;
      o_illegal <= bad_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_opcode <= '0;
      o_class  <= '0;
      o_kind   <= '0;
      o_reg_a  <= '0;
      o_reg_b  <= '0;
      o_imm    <= '0;
      o_len    <= '0;
    end else if (good_n) begin
      o_opcode <= fin_opc;
      o_class  <= cls;
      o_kind   <= fin_info.kind;
      o_reg_a  <= reg_a;
      o_reg_b  <= reg_b;
      o_imm    <= fin_imm;
      o_len    <= fin_info.len;
    end
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import vdec_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              dec_valid,
  output logic              dec_illegal,
  output logic [BYTE_W-1:0] dec_opcode,
  output logic [2:0]        dec_class,
  output logic [2:0]        dec_kind,
  output logic [REG_W-1:0]  dec_reg_a,
  output logic [REG_W-1:0]  dec_reg_b,
  output logic [IMM_W-1:0]  dec_imm,
  output logic [LEN_W-1:0]  dec_len
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              fin;
  op_info_t          fin_info;
  logic [BYTE_W-1:0] fin_opc, fin_regbyte;
  logic [IMM_W-1:0]  fin_imm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  vdec_collect u_collect (
    .clk(clk), .rst_n(rst_core_n), .in_valid(in_valid), .in_byte(in_byte),
    .fin(fin), .fin_info(fin_info), .fin_opc(fin_opc),
    .fin_regbyte(fin_regbyte), .fin_imm(fin_imm)
  );

  vdec_finish #(.NUM_REGS(NUM_REGS)) u_finish (
    .clk(clk), .rst_n(rst_core_n), .fin(fin), .fin_info(fin_info),
    .fin_opc(fin_opc), .fin_regbyte(fin_regbyte), .fin_imm(fin_imm),
    .o_valid(dec_valid), .o_illegal(dec_illegal), .o_opcode(dec_opcode),
    .o_class(dec_class), .o_kind(dec_kind), .o_reg_a(dec_reg_a),
    .o_reg_b(dec_reg_b), .o_imm(dec_imm), .o_len(dec_len)
  );
endmodule

// File: rtl/insn_decoder_checker.sv
module insn_decoder_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        dec_valid,
  input logic        dec_illegal,
  input logic [2:0]  dec_class,
  input logic [3:0]  dec_reg_a,
  input logic [3:0]  dec_reg_b,
  input logic [31:0] dec_imm,
  input logic [7:0]  dec_opcode,
  input logic [2:0]  dec_len
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_valid && dec_illegal)); // R8
  AST_VALID_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid)); // R2
  AST_ILLEGAL_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_illegal |-> $past(in_valid)); // R8
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_len == 3'd1 || dec_len == 3'd2 || dec_len == 3'd3 ||
                   dec_len == 3'd5 || dec_len == 3'd6)); // R2
  AST_REG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (dec_reg_a < 4'd7 && dec_reg_b < 4'd7)); // R9
  AST_RET_IS_IP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_class == 3'd4) |-> (dec_reg_a == 4'd4 && dec_opcode == 8'h22)); // R7
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> ($stable(dec_imm) && $stable(dec_opcode))); // R10
endmodule

bind insn_decoder insn_decoder_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_valid(dec_valid),
  .dec_illegal(dec_illegal), .dec_class(dec_class), .dec_reg_a(dec_reg_a),
  .dec_reg_b(dec_reg_b), .dec_imm(dec_imm), .dec_opcode(dec_opcode),
  .dec_len(dec_len)
);

// File: tb/insn_decoder_test.sv
`timescale 1ns/1ps
module insn_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        dec_valid, dec_illegal;
  logic [7:0]  dec_opcode;
  logic [2:0]  dec_class, dec_kind, dec_len;
  logic [3:0]  dec_reg_a, dec_reg_b;
  logic [31:0] dec_imm;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0]  ib [0:5];
  logic [31:0] held_imm = 32'h0;
  logic [7:0]  held_opc = 8'h0;

  always #2 clk = ~clk;

  insn_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .dec_valid(dec_valid), .dec_illegal(dec_illegal), .dec_opcode(dec_opcode),
    .dec_class(dec_class), .dec_kind(dec_kind), .dec_reg_a(dec_reg_a),
    .dec_reg_b(dec_reg_b), .dec_imm(dec_imm), .dec_len(dec_len)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int m_len(input logic [7:0] o);
    if (o == 8'h90 || o == 8'hF0) return 1;
    if (o == 8'h50) return 3;
    if (o == 8'h21 || o == 8'h23 || o == 8'h30 || (o >= 8'h40 && o <= 8'h47)) return 5;
    if (o == 8'h01 || o == 8'h03 || (o >= 8'h0C && o <= 8'h14)) return 6;
    if (o == 8'h02 || (o >= 8'h04 && o <= 8'h0B) || o == 8'h15 || o == 8'h16 ||
        o == 8'h20 || o == 8'h22 || o == 8'h24 || o == 8'h31 ||
        (o >= 8'h48 && o <= 8'h4F)) return 2;
    return 0;
  endfunction

  function automatic int m_class(input logic [7:0] o);
    if ((o >= 8'h01 && o <= 8'h05) || o == 8'h14) return 0;
    if ((o >= 8'h06 && o <= 8'h13) || o == 8'h15 || o == 8'h16) return 1;
    if (o >= 8'h20 && o <= 8'h22) return 2;
    if (o == 8'h50) return 5;
    if (o == 8'h90) return 6;
    if (o == 8'hF0) return 7;
    return 3;
  endfunction

  function automatic int m_kind(input logic [7:0] o);
    if (o == 8'h04 || o == 8'h05) return 5;
    if (o == 8'h50) return 4;
    if (o == 8'h03 || o == 8'h23 || o == 8'h30 || (o >= 8'h40 && o <= 8'h47)) return 3;
    if (o == 8'h01 || (o >= 8'h0C && o <= 8'h14) || o == 8'h21) return 2;
    if (o == 8'h90 || o == 8'hF0) return 0;
    return 1;
  endfunction

  // 0 none, 1 upper nibble, 2 lower nibble, 3 both
  function automatic int m_sel(input logic [7:0] o);
    if (o == 8'h02 || (o >= 8'h04 && o <= 8'h0B)) return 3;
    if (o == 8'h01 || o == 8'h03 || (o >= 8'h0C && o <= 8'h16) || o == 8'h22 || o == 8'h50) return 1;
    if (o == 8'h20 || o == 8'h24 || o == 8'h31 || (o >= 8'h48 && o <= 8'h4F)) return 2;
    return 0;
  endfunction

  task automatic idle_check();
    chk("R10", "valid in idle", {31'b0, dec_valid}, 32'h0);
    chk("R10", "illegal in idle", {31'b0, dec_illegal}, 32'h0);
    chk("R10", "imm held", dec_imm, held_imm);
  endtask

  task automatic do_insn(input int n, input int gap_max);
    logic [7:0]  o;
    int          len, sel, cls;
    logic [3:0]  ea, eb;
    logic [31:0] eimm;
    bit          ok;
    o   = ib[0];
    len = m_len(o);
    sel = m_sel(o);
    ea = 4'h0; eb = 4'h0;
    if (sel == 1 || sel == 3) ea = ib[1][7:4];
    if (sel == 2) ea = ib[1][3:0];
    if (sel == 3) eb = ib[1][3:0];
    ok = (len != 0) && (ea < 4'd7) && (eb < 4'd7);
    eimm = 32'h0;
    if (len == 6) eimm = {ib[5], ib[4], ib[3], ib[2]};
    if (len == 5) eimm = {ib[4], ib[3], ib[2], ib[1]};
    if (len == 3) eimm = {24'h0, ib[2]};
    cls = m_class(o);
    if (o == 8'h22 && ea == 4'd4) cls = 4;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_byte  = ib[i];
      @(negedge clk);
      in_valid = 1'b0;
      if (i < n - 1) begin
        chk("R2", "early valid", {31'b0, dec_valid}, 32'h0);
        chk("R2", "early illegal", {31'b0, dec_illegal}, 32'h0);
      end else if (len == 0) begin
        chk("R8", "valid on bad opcode", {31'b0, dec_valid}, 32'h0);
        chk("R8", "illegal on bad opcode", {31'b0, dec_illegal}, 32'h1);
        chk("R10", "imm held on illegal", dec_imm, held_imm);
        chk("R10", "opcode held on illegal", {24'h0, dec_opcode}, {24'h0, held_opc});
      end else if (!ok) begin
        chk("R9", "valid on bad reg", {31'b0, dec_valid}, 32'h0);
        chk("R9", "illegal on bad reg", {31'b0, dec_illegal}, 32'h1);
        chk("R10", "imm held on illegal", dec_imm, held_imm);
      end else begin
        chk("R2", "valid", {31'b0, dec_valid}, 32'h1);
        chk("R2", "len", {29'b0, dec_len}, len);
        chk("R8", "no illegal", {31'b0, dec_illegal}, 32'h0);
        chk("R10", "opcode", {24'h0, dec_opcode}, {24'h0, o});
        if (cls == 4) chk("R7", "return class", {29'b0, dec_class}, cls);
        else          chk("R5", "class", {29'b0, dec_class}, cls);
        chk("R6", "kind", {29'b0, dec_kind}, m_kind(o));
        chk("R3", "reg a", {28'b0, dec_reg_a}, {28'b0, ea});
        chk("R3", "reg b", {28'b0, dec_reg_b}, {28'b0, eb});
        chk("R4", "imm", dec_imm, eimm);
        held_imm = eimm;
        held_opc = o;
      end
      if (gap_max > 0) begin
        int g;
        g = $urandom % (gap_max + 1);
        repeat (g) begin
          @(negedge clk);
          idle_check();
        end
      end
    end
  endtask

  task automatic set(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                     input logic [7:0] b3, input logic [7:0] b4, input logic [7:0] b5);
    ib[0] = b0; ib[1] = b1; ib[2] = b2; ib[3] = b3; ib[4] = b4; ib[5] = b5;
  endtask

  function automatic logic [3:0] rnib();
    if ($urandom % 6 == 0) return 4'(7 + $urandom % 9);
    return 4'($urandom % 7);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] o;
    void'($urandom(32'h1D3C_0A57));
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h0;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", {31'b0, dec_valid}, 32'h0);
    chk("R1", "illegal in reset", {31'b0, dec_illegal}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "valid after reset", {31'b0, dec_valid}, 32'h0);
    chk("R1", "illegal after reset", {31'b0, dec_illegal}, 32'h0);

    set(8'h90, 0, 0, 0, 0, 0);             do_insn(1, 0);
    set(8'hF0, 0, 0, 0, 0, 0);             do_insn(1, 1);
    set(8'h22, 8'h40, 0, 0, 0, 0);         do_insn(2, 0);
    set(8'h22, 8'h10, 0, 0, 0, 0);         do_insn(2, 0);
    set(8'h01, 8'h20, 8'h78, 8'h56, 8'h34, 8'h12); do_insn(6, 2);
    set(8'h40, 8'hEF, 8'hBE, 8'hAD, 8'hDE, 0);     do_insn(5, 0);
    set(8'h50, 8'h30, 8'h21, 0, 0, 0);     do_insn(3, 1);
    set(8'h00, 0, 0, 0, 0, 0);             do_insn(1, 0);
    set(8'h90, 0, 0, 0, 0, 0);             do_insn(1, 0);
    set(8'h02, 8'h17, 0, 0, 0, 0);         do_insn(2, 0);
    set(8'h15, 8'h27, 0, 0, 0, 0);         do_insn(2, 0);
    set(8'h20, 8'hF2, 0, 0, 0, 0);         do_insn(2, 0);
    set(8'h12, 8'h30, 8'h08, 0, 0, 0);     do_insn(6, 0);
    set(8'h04, 8'h56, 0, 0, 0, 0);         do_insn(2, 0);

    for (int k = 0; k < 3000; k++) begin
      o = 8'($urandom);
      if ($urandom % 8 != 0) begin
        while (m_len(o) == 0) o = 8'($urandom);
      end
      set(o, {rnib(), rnib()}, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
      do_insn((m_len(o) == 0) ? 1 : m_len(o), (k % 3 == 0) ? 0 : 2);
    end
    finish_run();
  end
endmodule